// File: doc/BRIEF.md
# Emulator Task Special-Function Decoder

This block decodes the emulator task's portion of one microinstruction in a 16-bit microcoded processor. Within a single cycle it takes the bus-source field, the two special-function fields, the instruction register and the M register. From these it forms the register-file read address and decides what the processor bus carries. It also raises single-cycle strobes toward the RAM-access logic and toward the attached device controllers.

It holds three pieces of state. The first is a 16-bit reset mode register that selects, per task, whether the task starts from ROM or RAM after a reset. The second is a 3-bit S-register bank pointer. The third is the S-register file itself, modelled here as a small array. The ALU, the shifter and the device controllers live elsewhere and only see the outputs.

Address modification and host-address masking are combinational. They take effect before the bus value is used by the register loads in the same cycle. All register updates happen on the rising clock edge.

Top module: `emu_func_decode`

## Requirements
- R1: With `bs` = 1 (read S), `bus_out` equals `m_in` when the effective register address `raddr` is 0. Otherwise it equals the S entry at the current bank and `raddr`.
- R2: With `bs` = 2 (load S), `bus_out` is 16'hFFFF and `load_s` is 1. At the clock edge, the S entry at the current bank and `raddr` takes `m_in`.
- R3: With `f2` = 1 (source accumulator), `raddr` = {`rsel`[4:2], `ir`[14:13] ^ 2'b11}. With `f2` = 0, `raddr` = `rsel`.
- R4: With `f2` = 2 (destination accumulator) or `f2` = 3 (novel shift), `raddr` = {`rsel`[4:2], `ir`[12:11] ^ 2'b11}.
- R5: With `f1` = 1, `rmr` takes all 16 bits of `bus_out` at the clock edge. Bit i is task i's start mode, where 1 means ROM and 0 means RAM. After reset, `rmr` is 16'hFFFF.
- R6: With `f1` = 3 (start) and `bus_out`[15] = 1, `soft_reset` is 1 and no device strobe or `unknown_dev` is raised.
- R7: With `f1` = 3 and `bus_out`[15] = 0, the code routes to one output. Codes 1 to 3 raise `start_net`, code 4 raises `start_raster`, and codes 16'h0010 and 16'h0020 raise `start_disk`. Code 0 raises nothing.
- R8: With `f1` = 3 and any other nonzero code with bit 15 clear, `unknown_dev` is 1 and no device strobe is raised.
- R9: With `f1` = 7, `bank` takes `bus_out`[3:1] at the clock edge when `big_ram` = 1, and takes 0 when `big_ram` = 0. `bank` is 0 after reset.
- R10: With `f1` = 2 (host address), `bus_out` is the ungated bus ANDed with {8'hFF, `host_addr`} when `net_present` = 1. When `net_present` = 0, the mask is all ones.
- R11: `illegal` is 1 exactly when `f1` > 7, `f2` > 3 or `bs` = 3.
- R12: `f1` = 4, 5 and 6 raise `swmode`, `rdram` and `wrtram` respectively for that cycle only. With `bs` = 0 and no host-address masking, `bus_out` equals `bus_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bs | input | 2 | Bus source: 0 external, 1 read S, 2 load S, 3 illegal |
| f1 | input | 4 | First special function |
| f2 | input | 4 | Second special function |
| rsel | input | 5 | Register select field |
| ir | input | 16 | Instruction register |
| m_in | input | 16 | M register |
| bus_in | input | 16 | Bus value from other sources |
| host_addr | input | 8 | Host address byte |
| net_present | input | 1 | Network interface fitted |
| big_ram | input | 1 | Strap for the large RAM configuration |
| raddr | output | 5 | Effective register address |
| bus_out | output | 16 | Processor bus |
| load_s | output | 1 | S-load strobe |
| rmr | output | 16 | Reset mode register |
| bank | output | 3 | S-register bank |
| soft_reset | output | 1 | Suppress next-address load |
| start_net | output | 1 | Network controller start |
| start_raster | output | 1 | Raster controller start |
| start_disk | output | 1 | Disk controller start |
| unknown_dev | output | 1 | Start code matched no device |
| swmode | output | 1 | Switch-mode strobe |
| rdram | output | 1 | RAM-read strobe |
| wrtram | output | 1 | RAM-write strobe |
| illegal | output | 1 | Unhandled function code |

## Verification
The hardest case to reach from the ports is banked S-register storage, because the array can only be seen through the read-S bus path. The stimulus first sets the bank to 7 with the large-RAM strap high. It then loads an S entry from M and reads it back. Next it returns to bank 0 and reads the same address, which must still hold the older value. A later bank load with the strap low must leave the bank at 0, even though the bus asks for 7.

// File: rtl/emu_func_decode.sv
module emu_func_decode #(
  parameter int DW     = 16,
  parameter int RW     = 5,
  parameter int BANK_W = 3,
  parameter int HOST_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bs,
  input  logic [3:0]        f1,
  input  logic [3:0]        f2,
  input  logic [RW-1:0]     rsel,
  input  logic [DW-1:0]     ir,
  input  logic [DW-1:0]     m_in,
  input  logic [DW-1:0]     bus_in,
  input  logic [HOST_W-1:0] host_addr,
  input  logic              net_present,
  input  logic              big_ram,
  output logic [RW-1:0]     raddr,
  output logic [DW-1:0]     bus_out,
  output logic              load_s,
  output logic [DW-1:0]     rmr,
  output logic [BANK_W-1:0] bank,
  output logic              soft_reset,
  output logic              start_net,
  output logic              start_raster,
  output logic              start_disk,
  output logic              unknown_dev,
  output logic              swmode,
  output logic              rdram,
  output logic              wrtram,
  output logic              illegal
);
  localparam int NENT = (1 << BANK_W) * (1 << RW);

  localparam logic [1:0] BS_READ = 2'd1, BS_LOAD = 2'd2, BS_BAD = 2'd3;
  localparam logic [3:0] F1_RMR = 4'd1, F1_HOST = 4'd2, F1_START = 4'd3, F1_SWM = 4'd4,
                         F1_RDR = 4'd5, F1_WRR = 4'd6, F1_BANK = 4'd7;
  localparam logic [3:0] F2_SRC = 4'd1, F2_DST = 4'd2, F2_DNS = 4'd3;

  logic [DW-1:0] sfile [NENT];
  logic [DW-1:0] bus_pre, host_mask;
  logic          start_v, dispatch;
  logic          unused_ir;

  assign unused_ir = ^{ir[DW-1], ir[10:0]};

  always_comb begin
    raddr = rsel;
    if (f2 == F2_SRC)
      raddr[1:0] = ir[14:13] ^ 2'b11;
    else if (f2 == F2_DST || f2 == F2_DNS)
      raddr[1:0] = ir[12:11] ^ 2'b11;
  end

  always_comb begin
    case (bs)
      BS_READ: bus_pre = (raddr == '0) ? m_in : sfile[{bank, raddr}];
      BS_LOAD: bus_pre = '1;
      default: bus_pre = bus_in;
    endcase
  end

  assign host_mask = {{(DW-HOST_W){1'b1}}, net_present ? host_addr : {HOST_W{1'b1}}};
  assign bus_out   = (f1 == F1_HOST) ? (bus_pre & host_mask) : bus_pre;
  assign load_s    = (bs == BS_LOAD);

  assign start_v      = (f1 == F1_START);
  assign soft_reset   = start_v && bus_out[DW-1];
  assign dispatch     = start_v && !bus_out[DW-1] && (bus_out != '0);
  assign start_net    = dispatch && (bus_out >= DW'(1)) && (bus_out <= DW'(3));
  assign start_raster = dispatch && (bus_out == DW'(4));
  assign start_disk   = dispatch && (bus_out == DW'(16) || bus_out == DW'(32));
  assign unknown_dev  = dispatch && !start_net && !start_raster && !start_disk;

  assign swmode  = (f1 == F1_SWM);
  assign rdram   = (f1 == F1_RDR);
  assign wrtram  = (f1 == F1_WRR);
  assign illegal = (f1 > F1_BANK) || (f2 > F2_DNS) || (bs == BS_BAD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rmr  <= '1;
      bank <= '0;
    end else begin
      if (f1 == F1_RMR)  rmr  <= bus_out;
      if (f1 == F1_BANK) bank <= big_ram ? bus_out[BANK_W:1] : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (bs == BS_LOAD) sfile[{bank, raddr}] <= m_in;
  end

  a_r1_zero_reads_m: assert property (@(posedge clk) disable iff (!rst_n)
    (bs == BS_READ && raddr == '0 && f1 != F1_HOST) |-> bus_out == m_in);
  a_r2_load_drives_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (load_s && f1 != F1_HOST) |-> bus_out == '1);
  a_r5_rmr_captures_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (f1 == F1_RMR) |=> rmr == $past(bus_out));
  a_r9_small_ram_bank0: assert property (@(posedge clk) disable iff (!rst_n)
    (f1 == F1_BANK && !big_ram) |=> bank == '0);
  a_r6_r8_single_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({soft_reset, start_net, start_raster, start_disk, unknown_dev}));
  a_r6_soft_no_dispatch: assert property (@(posedge clk) disable iff (!rst_n)
    soft_reset |-> !(start_net || start_raster || start_disk || unknown_dev));
endmodule

// File: tb/tb_emu_func_decode.sv
module tb_emu_func_decode;
  logic clk = 0, rst_n = 0;
  logic [1:0] bs = 0;
  logic [3:0] f1 = 0, f2 = 0;
  logic [4:0] rsel = 0;
  logic [15:0] ir = 0, m_in = 0, bus_in = 0;
  logic [7:0] host_addr = 0;
  logic net_present = 0, big_ram = 0;
  logic [4:0] raddr;
  logic [15:0] bus_out, rmr;
  logic [2:0] bank;
  logic load_s, soft_reset, start_net, start_raster, start_disk, unknown_dev;
  logic swmode, rdram, wrtram, illegal;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  emu_func_decode dut (.*);

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    bs = 0; f1 = 0; f2 = 0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    idle(); rst_n = 0; tick(); tick(); rst_n = 1; tick();
  endtask

  task automatic t_reset();
    chk("R5 reset rmr", rmr, 16'hFFFF);
    chk("R9 reset bank", {13'd0, bank}, 16'd0);
    chk("R11 idle illegal", {15'd0, illegal}, 16'd0);
    bus_in = 16'h3C5A; #1;
    chk("R12 bus passthrough", bus_out, 16'h3C5A);
  endtask

  task automatic t_read_load();
    bs = 1; rsel = 0; m_in = 16'hABCD; #1;
    chk("R1 rsel0 reads M", bus_out, 16'hABCD);
    bs = 2; rsel = 5; m_in = 16'h1234; #1;
    chk("R2 load bus ones", bus_out, 16'hFFFF);
    chk("R2 load strobe", {15'd0, load_s}, 16'd1);
    tick();
    bs = 1; rsel = 5; m_in = 16'h0000; #1;
    chk("R1 read S entry", bus_out, 16'h1234);
    idle(); #1;
    chk("R2 strobe drops", {15'd0, load_s}, 16'd0);
  endtask

  task automatic t_acaddr();
    rsel = 5'b10101;
    ir = 16'h2000; f2 = 1; #1;
    chk("R3 source address", {11'd0, raddr}, 16'h0016);
    f2 = 0; #1;
    chk("R3 plain address", {11'd0, raddr}, 16'h0015);
    ir = 16'h1800; f2 = 2; #1;
    chk("R4 dest address", {11'd0, raddr}, 16'h0014);
    ir = 16'h0000; f2 = 3; #1;
    chk("R4 shift address", {11'd0, raddr}, 16'h0017);
    idle();
  endtask

  task automatic t_rmr();
    f1 = 1; bs = 0; bus_in = 16'h5A5A; tick(); idle(); #1;
    chk("R5 rmr load", rmr, 16'h5A5A);
    do_reset();
    chk("R5 rmr after reset", rmr, 16'hFFFF);
  endtask

  task automatic t_start(input logic [15:0] code, input logic [4:0] exp);
    f1 = 3; bs = 0; bus_in = code; #1;
    chk("R6 soft reset", {15'd0, soft_reset}, {15'd0, exp[4]});
    chk("R7 net", {15'd0, start_net}, {15'd0, exp[3]});
    chk("R7 raster", {15'd0, start_raster}, {15'd0, exp[2]});
    chk("R7 disk", {15'd0, start_disk}, {15'd0, exp[1]});
    chk("R8 unknown", {15'd0, unknown_dev}, {15'd0, exp[0]});
    idle(); #1;
  endtask

  task automatic t_bank();
    big_ram = 1; f1 = 7; bus_in = 16'h000E; tick(); idle(); #1;
    chk("R9 bank load", {13'd0, bank}, 16'd7);
    bs = 2; rsel = 5; m_in = 16'h7777; tick();
    bs = 1; m_in = 0; #1;
    chk("R9 bank7 entry", bus_out, 16'h7777);
    idle(); f1 = 7; bus_in = 16'h0000; tick(); idle();
    bs = 1; rsel = 5; #1;
    chk("R9 bank0 entry kept", bus_out, 16'h1234);
    idle(); big_ram = 0; f1 = 7; bus_in = 16'h000E; tick(); idle(); #1;
    chk("R9 small ram forces 0", {13'd0, bank}, 16'd0);
  endtask

  task automatic t_host();
    bs = 0; bus_in = 16'h1234; f1 = 2; net_present = 1; host_addr = 8'h5C; #1;
    chk("R10 host mask", bus_out, 16'h1214);
    net_present = 0; bus_in = 16'hFFFF; #1;
    chk("R10 absent ones", bus_out, 16'hFFFF);
    bus_in = 16'h1234; #1;
    chk("R10 absent unchanged", bus_out, 16'h1234);
    idle();
  endtask

  task automatic t_strobes_illegal();
    f1 = 4; #1; chk("R12 swmode", {13'd0, swmode, rdram, wrtram}, 16'b100);
    f1 = 5; #1; chk("R12 rdram", {13'd0, swmode, rdram, wrtram}, 16'b010);
    f1 = 6; #1; chk("R12 wrtram", {13'd0, swmode, rdram, wrtram}, 16'b001);
    chk("R11 legal f1", {15'd0, illegal}, 16'd0);
    f1 = 8; #1; chk("R11 bad f1", {15'd0, illegal}, 16'd1);
    f1 = 0; f2 = 4; #1; chk("R11 bad f2", {15'd0, illegal}, 16'd1);
    f2 = 3; #1; chk("R11 legal f2", {15'd0, illegal}, 16'd0);
    f2 = 0; bs = 3; #1; chk("R11 bad bs", {15'd0, illegal}, 16'd1);
    idle(); #1;
    chk("R12 strobes idle", {13'd0, swmode, rdram, wrtram}, 16'd0);
  endtask

  initial begin
    #150000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    t_reset();
    t_read_load();
    t_acaddr();
    t_rmr();
    t_start(16'h8000, 5'b10000);
    t_start(16'h8003, 5'b10000);
    t_start(16'h0001, 5'b01000);
    t_start(16'h0003, 5'b01000);
    t_start(16'h0004, 5'b00100);
    t_start(16'h0010, 5'b00010);
    t_start(16'h0020, 5'b00010);
    t_start(16'h0005, 5'b00001);
    t_start(16'h0000, 5'b00000);
    t_bank();
    t_host();
    t_strobes_illegal();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule